// File: doc/BRIEF.md
# Three-Wire Configuration Word Sender

This block lives on the host side of a board-level clock source that takes its configuration over a three-wire serial link made of a bit clock, a data line and a latch strobe. A system-clock agent presents a configuration word and pulses `start_i`. The block then shifts the word out most significant bit first, one serial clock pulse per bit. Once the last bit is in, it waits out a settling gap and raises the latch strobe for a fixed width.

All serial timing comes from the system clock. Five parameters set how many system cycles data leads the rising serial clock edge, how long the serial clock stays high, how long data is held after the serial clock falls, the gap before the strobe, and the strobe width. With a 100 MHz system clock the defaults give at least 10 ns of setup, hold and gap, a strobe of at least 40 ns, and a serial clock no faster than 50 MHz. The strobe stays low for the whole shift, so the device only takes the new word as a complete unit. `busy_o` covers the transaction and `done_o` marks its end.

Top module: `cfg_serial_master`

## Requirements
- R1: The bits sampled on the data line at the rising edges of the serial clock, taken in order, equal the accepted word, bit WORD_W-1 first and bit 0 last.
- R2: The data line is stable while the serial clock is high, and each bit is driven for exactly SETUP_CYC cycles with the serial clock low before that clock rises.
- R3: The serial clock stays high for exactly HIGH_CYC cycles per bit, and the data line changes only when the serial clock has been low for at least one full cycle, that is, HOLD_CYC cycles after it falls.
- R4: Each transaction produces exactly WORD_W serial clock pulses.
- R5: The strobe stays low during every serial clock pulse, and it rises after exactly HOLD_CYC+WAIT_CYC low cycles that follow the last serial clock high cycle.
- R6: The strobe stays high for exactly STB_CYC cycles.
- R7: A start request sampled while `busy_o` is high has no effect on the serial lines or on the transaction in progress.
- R8: `busy_o` rises in the cycle after an accepted start and stays high through the last strobe-high cycle.
- R9: `done_o` is high for exactly one cycle, namely the cycle after the strobe falls, with `busy_o` low. A start sampled in that cycle is accepted.
- R10: At reset and while idle, the serial clock and the strobe are low. After reset the data line is low; after a transaction it holds the word's bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| word_i | input | WORD_W | Configuration word, captured on an accepted start |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sclk_o | output | 1 | Serial bit clock |
| sdata_o | output | 1 | Serial data |
| strobe_o | output | 1 | Latch strobe |

## Verification
On every cycle the bound assertions check the local rules. Data stays stable while the serial clock is high, and changes only after a full low cycle. The strobe is never high together with the serial clock, and it comes only after WORD_W pulses. Busy covers both the serial clock and the strobe, idle lines stay low, and done is a single pulse that follows the strobe's fall. The exact cycle counts need the bench's cycle-by-cycle model: the setup, high, hold, gap and strobe widths, and the MSB-first bit order across data patterns. The bench also shows that a start during busy is ignored and that a start in the done cycle is taken.

// File: rtl/cfg_serial_master.sv
module cfg_serial_master #(
  parameter int WORD_W    = 24,
  parameter int SETUP_CYC = 1,
  parameter int HIGH_CYC  = 2,
  parameter int HOLD_CYC  = 1,
  parameter int WAIT_CYC  = 1,
  parameter int STB_CYC   = 4,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              strobe_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] SU_L = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HI_L = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] HO_L = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] WT_L = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] SB_L = CNT_W'(STB_CYC - 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

  typedef enum logic [2:0] {IDLE, SETUP, HIGH, HOLD, GAP, STB} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] sh;
  logic [BIT_W-1:0] nbit;
  logic             done_q;
  wire              expired = (cnt == '0);

  assign busy_o   = (st != IDLE);
  assign sclk_o   = (st == HIGH);
  assign strobe_o = (st == STB);
  assign sdata_o  = sh[WORD_W-1];
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      sh     <= '0;
      nbit   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start_i) begin
          st   <= SETUP;
          cnt  <= SU_L;
          sh   <= word_i;
          nbit <= LAST;
        end
        SETUP: if (expired) begin
          st  <= HIGH;
          cnt <= HI_L;
        end else cnt <= cnt - 1'b1;
        HIGH: if (expired) begin
          st  <= HOLD;
          cnt <= HO_L;
        end else cnt <= cnt - 1'b1;
        HOLD: if (expired) begin
          if (nbit == '0) begin
            st  <= GAP;
            cnt <= WT_L;
          end else begin
            st   <= SETUP;
            cnt  <= SU_L;
            sh   <= sh << 1;
            nbit <= nbit - 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        GAP: if (expired) begin
          st  <= STB;
          cnt <= SB_L;
        end else cnt <= cnt - 1'b1;
        STB: if (expired) begin
          st     <= IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_master_chk.sv
module cfg_serial_master_chk #(
  parameter int WORD_W = 24
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic strobe_o
);
  localparam int RW = $clog2(WORD_W + 2) + 1;
  logic [RW-1:0] rises;
  logic          sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (!busy_o) rises <= '0;
      else if (sclk_o && !sclk_q) rises <= rises + 1'b1;
    end
  end

  assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdata_o));
  assert_data_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> (!sclk_o && !$past(sclk_o)));
  assert_pulse_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rises) <= WORD_W);
  assert_strobe_after_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (!sclk_o && int'(rises) == WORD_W));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !strobe_o) |=> busy_o);
  assert_busy_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o || strobe_o) |-> busy_o);
  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> (done_o && !busy_o));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !strobe_o));
endmodule

bind cfg_serial_master cfg_serial_master_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .strobe_o(strobe_o)
);

// File: tb/cfg_serial_master_tb_top.sv
module cfg_serial_master_tb_top;
  localparam int W = 24, SU = 2, HI = 3, HO = 2, WT = 4, SB = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] word = '0;
  logic busy, done, sclk, sdata, stb;

  always #5 clk = ~clk;

  cfg_serial_master #(.WORD_W(W), .SETUP_CYC(SU), .HIGH_CYC(HI), .HOLD_CYC(HO),
                      .WAIT_CYC(WT), .STB_CYC(SB), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(word), .busy_o(busy),
    .done_o(done), .sclk_o(sclk), .sdata_o(sdata), .strobe_o(stb));

  int checks = 0, fails = 0;
  logic [4:0] q[$];
  logic [4:0] expv = '0;
  logic last_d = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      repeat (SU) q.push_back({1'b0, w[i], 3'b010});
      repeat (HI) q.push_back({1'b1, w[i], 3'b010});
      repeat (HO) q.push_back({1'b0, w[i], 3'b010});
    end
    repeat (WT) q.push_back({1'b0, w[0], 3'b010});
    repeat (SB) q.push_back({1'b0, w[0], 3'b110});
    q.push_back({1'b0, w[0], 3'b001});
    last_d = w[0];
  endtask

  // reference model: expected {sclk,data,strobe,busy,done} after each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      expv = '0;
      last_d = 1'b0;
    end else begin
      if (q.size() == 0 && start) build(word);
      if (q.size() > 0) expv = q.pop_front();
      else expv = {1'b0, last_d, 3'b000};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3 sclk per cycle", 32'(sclk), 32'(expv[4]));
      chk("R1/R2 data per cycle", 32'(sdata), 32'(expv[3]));
      chk("R5/R6 strobe per cycle", 32'(stb), 32'(expv[2]));
      chk("R7/R8 busy per cycle", 32'(busy), 32'(expv[1]));
      chk("R9 done per cycle", 32'(done), 32'(expv[0]));
    end
  end

  // monitor for transaction-level measurements
  logic [W-1:0] cap = '0;
  int rises = 0, gap = 0, gap_at = -1, stbw = 0;
  logic pb = 1'b0, ps = 1'b0, pt = 1'b0;
  always @(negedge clk) begin
    if (busy && !pb) begin
      rises = 0; cap = '0; gap = 0; gap_at = -1; stbw = 0;
    end
    if (sclk && !ps) begin
      rises++;
      cap = {cap[W-2:0], sdata};
    end
    if (sclk) gap = 0;
    else if (busy && !stb) gap++;
    if (stb && !pt) gap_at = gap;
    if (stb) stbw++;
    pb = busy; ps = sclk; pt = stb;
  end

  task automatic send(logic [W-1:0] w, bit poke);
    int n = 0;
    word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      word = ~w;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      word = w;
    end
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk("R1 captured word", 32'(cap), 32'(w));
    chk("R4 pulse count", 32'(rises), 32'(W));
    chk("R5 gap before strobe", 32'(gap_at), 32'(HO + WT));
    chk("R6 strobe width", 32'(stbw), 32'(SB));
    chk("R9 done with busy low", 32'({done, busy}), 32'(2'b10));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", 32'(sclk), 0);
    chk("R10 reset strobe", 32'(stb), 0);
    chk("R10 reset data", 32'(sdata), 0);
    chk("R8 reset busy", 32'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(24'hA5C33C, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 idle data holds bit 0", 32'({sclk, sdata, stb}), 32'(3'b000));
    send(24'hFFFFFF, 1'b1);          // R7: start pulsed mid-transaction
    repeat (3) @(negedge clk);
    chk("R10 idle data holds bit 0", 32'({sclk, sdata, stb}), 32'(3'b010));
    send(24'h000000, 1'b0);
    send(24'h800001, 1'b0);          // R9: start in the done cycle
    send(24'h5A5A5B, 1'b1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule